// File: doc/BRIEF.md
# Sound Generator Register Front End and Tone Section

This block is the byte-wide write port and square-wave tone section of a four-channel sound generator. A host writes single bytes. A byte with its top bit set is a latch byte: it selects one of eight internal registers and loads that register's low nibble. A byte with its top bit clear is a data byte: it goes to whichever register was latched last, and for a tone period it fills the upper six bits of the 10-bit period. The block holds three tone periods, four 4-bit attenuation codes (0 is loudest) and a 4-bit noise control value.

A parameterised divider turns the input clock into a tick. On every tick, three tone down-counters run, and each one flips its square-wave level when it expires. After any write, a small READY sequencer (states RDY_IDLE, RDY_WAIT, RDY_HOLD) pulls READY low. It returns to RDY_IDLE on the second tick after the write. The transitions are: any state to RDY_WAIT on a write; RDY_WAIT to RDY_HOLD on a tick; RDY_HOLD to RDY_IDLE on a tick. The noise generator and the mixer sit outside this block. They take the volume codes, the noise control value with its update strobe, and the raw tone 2 period from its outputs.

Two variant switches exist. SHORT_ZERO makes a zero period mean "toggle on every tick" and starts the register pointer at 3. STRICT_DATA drops data bytes aimed at volume or noise registers.

Top module: `psg_tone_core`

## Requirements
- R1: A byte with bit 7 = 1 stores bits 6:4 as the register pointer and writes bits 3:0 into the low nibble of that register.
- R2: A byte with bit 7 = 0 aimed at a tone period register writes its bits 5:0 into period bits 9:4 and leaves bits 3:0 unchanged.
- R3: A byte with bit 7 = 0 aimed at a volume or noise register replaces that register's 4-bit value with bits 3:0 (when STRICT_DATA = 0).
- R4: Registers 0, 2 and 4 are the tone periods of channels 0, 1 and 2. Registers 1, 3, 5 and 7 are the volumes of channels 0 to 3, and the volume of channel i appears on vol_code[4i+3:4i]. Register 6 is noise control.
- R5: After reset, every register and tone level is 0 and ready is 1. The pointer is 0, or 3 when SHORT_ZERO = 1.
- R6: The tick occurs once every DIV clocks. The first tick comes on the DIV-th rising edge after reset is released.
- R7: On each tick, a tone counter at 1 or below toggles its level and reloads its effective period; otherwise it decrements. For a period P, each half wave therefore lasts P×DIV clocks.
- R8: A period of 0 acts as 1024 when SHORT_ZERO = 0, and as 0 (toggle on every tick) when SHORT_ZERO = 1.
- R9: Every write, including one that is dropped, drives ready low on the next clock. Ready stays low for at least DIV+1 and at most 2×DIV clocks after the last write.
- R10: When STRICT_DATA = 1, data bytes aimed at registers 1, 3, 5, 6 or 7 change nothing, while data bytes aimed at tone periods are still applied.
- R11: An applied write to register 6 updates noise_ctl and raises noise_wr for exactly the following clock.
- R12: Register writes take effect on the next clock edge whatever the tick phase, and tone2_per shows the raw register 4 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_byte | input | 8 | Byte written with the strobe |
| ready | output | 1 | High when no write is pending |
| tone_lvl | output | 3 | Square-wave level of tone channels 2..0 |
| vol_code | output | 16 | Four 4-bit attenuation codes, channel i at bits 4i+3:4i |
| noise_ctl | output | 4 | Noise control register value |
| noise_wr | output | 1 | Pulses for one clock after register 6 is written |
| tone2_per | output | 10 | Raw period register of tone channel 2 |

## Verification
A write and a divider tick can land in the same clock. The register file must then still capture the byte, the READY sequencer must let the write win over the tick, and the tone counter may reload in that very clock. The undivided instance ticks on every clock, so every write it receives collides with a tick. Its period change is judged by the measured half-wave length and its READY timing by the exact two-clock low window. With a divider of 8, writes fall at varying phases, and READY is bounded on both sides.

// File: rtl/psg_pkg.sv
package psg_pkg;

    localparam int PER_W     = 10;
    localparam int VOL_W     = 4;
    localparam int NUM_TONE  = 3;
    localparam int NUM_VOL   = 4;
    localparam int SEL_W     = 3;
    localparam int CNT_W     = PER_W + 1;
    localparam int NOISE_SEL = 6;

    localparam logic [CNT_W-1:0] ZERO_RELOAD = CNT_W'(1) << PER_W;

    typedef enum logic [1:0] {
        RDY_IDLE,
        RDY_WAIT,
        RDY_HOLD
    } rdy_state_t;

    // Reload value used by a tone counter for a programmed period.
    function automatic logic [CNT_W-1:0] eff_period(input logic [PER_W-1:0] p,
                                                    input bit short_zero);
        logic [CNT_W-1:0] r;
        r = {1'b0, p};
        if (p == '0 && !short_zero) begin
            r = ZERO_RELOAD;
        end
        return r;
    endfunction

endpackage

// File: rtl/psg_tick_div.sv
module psg_tick_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= LAST;
        end else if (cnt == '0) begin
            cnt <= LAST;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = (cnt == '0);

endmodule

// File: rtl/psg_regs.sv
module psg_regs
    import psg_pkg::*;
#(
    parameter bit SHORT_ZERO  = 1'b0,
    parameter bit STRICT_DATA = 1'b0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [7:0]                         wr_byte,
    output logic [NUM_TONE-1:0][PER_W-1:0]     per,
    output logic [NUM_VOL-1:0][VOL_W-1:0]      vol,
    output logic [VOL_W-1:0]                   noise_ctl,
    output logic                               noise_wr,
    output logic [SEL_W-1:0]                   last_sel
);
    localparam logic [SEL_W-1:0] PTR_INIT = SHORT_ZERO ? SEL_W'(3) : SEL_W'(0);

    logic             is_latch;
    logic [SEL_W-1:0] tgt;
    logic             drop;
    logic             apply;

    assign is_latch = wr_byte[7];
    assign tgt      = is_latch ? wr_byte[6:4] : last_sel;
    assign drop     = STRICT_DATA && !is_latch &&
                      (tgt[0] || tgt == SEL_W'(NOISE_SEL));
    assign apply    = wr_en && !drop;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per       <= '0;
            vol       <= '0;
            noise_ctl <= '0;
            noise_wr  <= 1'b0;
            last_sel  <= PTR_INIT;
        end else begin
            noise_wr <= 1'b0;
            if (wr_en && is_latch) begin
                last_sel <= wr_byte[6:4];
            end
            if (apply) begin
                for (int i = 0; i < NUM_TONE; i++) begin
                    if (tgt == SEL_W'(2 * i)) begin
                        if (is_latch) begin
                            per[i][3:0] <= wr_byte[3:0];
                        end else begin
                            per[i][PER_W-1:4] <= wr_byte[5:0];
                        end
                    end
                end
                for (int i = 0; i < NUM_VOL; i++) begin
                    if (tgt == SEL_W'(2 * i + 1)) begin
                        vol[i] <= wr_byte[3:0];
                    end
                end
                if (tgt == SEL_W'(NOISE_SEL)) begin
                    noise_ctl <= wr_byte[3:0];
                    noise_wr  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/psg_tone_ch.sv
module psg_tone_ch
    import psg_pkg::*;
#(
    parameter bit SHORT_ZERO = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             level
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            level <= 1'b0;
        end else if (tick) begin
            if (cnt <= CNT_W'(1)) begin
                level <= ~level;
                cnt   <= eff_period(period, SHORT_ZERO);
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/psg_ready_fsm.sv
module psg_ready_fsm
    import psg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic tick,
    output logic ready
);
    rdy_state_t state;
    rdy_state_t state_nx;

    always_comb begin
        state_nx = state;
        if (wr_en) begin
            state_nx = RDY_WAIT;
        end else begin
            unique case (state)
                RDY_IDLE: state_nx = RDY_IDLE;
                RDY_WAIT: if (tick) state_nx = RDY_HOLD;
                RDY_HOLD: if (tick) state_nx = RDY_IDLE;
                default:  state_nx = RDY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RDY_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            RDY_IDLE: ready = 1'b1;
            RDY_WAIT: ready = 1'b0;
            RDY_HOLD: ready = 1'b0;
            default:  ready = 1'b1;
        endcase
    end

endmodule

// File: rtl/psg_tone_core.sv
module psg_tone_core
    import psg_pkg::*;
#(
    parameter int DIV         = 8,
    parameter bit SHORT_ZERO  = 1'b0,
    parameter bit STRICT_DATA = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [7:0]               wr_byte,
    output logic                     ready,
    output logic [NUM_TONE-1:0]      tone_lvl,
    output logic [NUM_VOL*VOL_W-1:0] vol_code,
    output logic [VOL_W-1:0]         noise_ctl,
    output logic                     noise_wr,
    output logic [PER_W-1:0]         tone2_per
);
    logic                           tick;
    logic [NUM_TONE-1:0][PER_W-1:0] per;
    logic [NUM_VOL-1:0][VOL_W-1:0]  vol;
    logic [SEL_W-1:0]               last_sel;

    psg_tick_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    psg_regs #(.SHORT_ZERO(SHORT_ZERO), .STRICT_DATA(STRICT_DATA)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .per       (per),
        .vol       (vol),
        .noise_ctl (noise_ctl),
        .noise_wr  (noise_wr),
        .last_sel  (last_sel)
    );

    generate
        for (genvar g = 0; g < NUM_TONE; g++) begin : g_tone
            psg_tone_ch #(.SHORT_ZERO(SHORT_ZERO)) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .period (per[g]),
                .level  (tone_lvl[g])
            );
        end
    endgenerate

    psg_ready_fsm u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .tick  (tick),
        .ready (ready)
    );

    assign vol_code  = vol;
    assign tone2_per = per[NUM_TONE-1];

endmodule

// File: rtl/psg_tone_core_chk.sv
module psg_tone_core_chk
    import psg_pkg::*;
#(
    parameter int DIV         = 8,
    parameter bit STRICT_DATA = 1'b0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [7:0]               wr_byte,
    input logic                     ready,
    input logic [NUM_TONE-1:0]      tone_lvl,
    input logic [NUM_VOL*VOL_W-1:0] vol_code,
    input logic [VOL_W-1:0]         noise_ctl,
    input logic                     noise_wr,
    input logic [PER_W-1:0]         tone2_per,
    input logic                     tick,
    input logic [SEL_W-1:0]         last_sel
);
    localparam int LW = $clog2(2 * DIV + 2) + 1;

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || wr_en || ready) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    a_r1_latch_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte[7]) |=> (last_sel == $past(wr_byte[6:4])));

    a_r1_latch_vol0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte[7] && wr_byte[6:4] == 3'd1) |=> (vol_code[3:0] == $past(wr_byte[3:0])));

    a_r1_latch_tone2_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte[7] && wr_byte[6:4] == 3'd4) |=> (tone2_per[3:0] == $past(wr_byte[3:0])));

    a_r2_tone2_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte[7] && last_sel == 3'd4) |=> (tone2_per[PER_W-1:4] == $past(wr_byte[5:0])));

    a_r7_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tone_lvl) |-> $past(tick));

    a_r9_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ready);

    a_r9_ready_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (low_cnt <= LW'(2 * DIV)));

    a_r10_strict_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (STRICT_DATA && wr_en && !wr_byte[7] && (last_sel[0] || last_sel == 3'd6))
        |=> ($stable(vol_code) && $stable(noise_ctl) && !noise_wr));

    a_r11_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        noise_wr |-> $past(wr_en));

endmodule

bind psg_tone_core psg_tone_core_chk #(.DIV(DIV), .STRICT_DATA(STRICT_DATA)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_byte   (wr_byte),
    .ready     (ready),
    .tone_lvl  (tone_lvl),
    .vol_code  (vol_code),
    .noise_ctl (noise_ctl),
    .noise_wr  (noise_wr),
    .tone2_per (tone2_per),
    .tick      (tick),
    .last_sel  (last_sel)
);

// File: tb/test_psg_tone_core.sv
`timescale 1ns/1ps
module test_psg_tone_core;

    localparam int LIM = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en   [3];
    logic [7:0] wr_byte [3];
    logic       ready   [3];
    logic [2:0] lvl     [3];
    logic [15:0] vol    [3];
    logic [3:0] nctl    [3];
    logic       nwr     [3];
    logic [9:0] t2p     [3];

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    // index 0: default, divide by 8
    psg_tone_core #(.DIV(8), .SHORT_ZERO(1'b0), .STRICT_DATA(1'b0)) i_psg_tone_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[0]), .wr_byte(wr_byte[0]),
        .ready(ready[0]), .tone_lvl(lvl[0]), .vol_code(vol[0]),
        .noise_ctl(nctl[0]), .noise_wr(nwr[0]), .tone2_per(t2p[0]));

    // index 1: short-zero variant, undivided
    psg_tone_core #(.DIV(1), .SHORT_ZERO(1'b1), .STRICT_DATA(1'b0)) i_psg_tone_core_sz (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[1]), .wr_byte(wr_byte[1]),
        .ready(ready[1]), .tone_lvl(lvl[1]), .vol_code(vol[1]),
        .noise_ctl(nctl[1]), .noise_wr(nwr[1]), .tone2_per(t2p[1]));

    // index 2: strict data variant, divide by 8
    psg_tone_core #(.DIV(8), .SHORT_ZERO(1'b0), .STRICT_DATA(1'b1)) i_psg_tone_core_st (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en[2]), .wr_byte(wr_byte[2]),
        .ready(ready[2]), .tone_lvl(lvl[2]), .vol_code(vol[2]),
        .noise_ctl(nctl[2]), .noise_wr(nwr[2]), .tone2_per(t2p[2]));

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input int d, input logic [7:0] b);
        @(negedge clk);
        wr_en[d]   = 1'b1;
        wr_byte[d] = b;
        @(negedge clk);
        wr_en[d]   = 1'b0;
    endtask

    // Clocks between two consecutive level changes of one tone channel.
    task automatic half_wave(input int d, input int ch, output int cyc);
        logic p;
        int   n;
        p = lvl[d][ch];
        n = 0;
        while (lvl[d][ch] == p && n < LIM) begin
            @(negedge clk);
            n++;
        end
        p = lvl[d][ch];
        n = 0;
        while (lvl[d][ch] == p && n < LIM) begin
            @(negedge clk);
            n++;
        end
        cyc = n;
    endtask

    task automatic t_reset;
        for (int d = 0; d < 3; d++) begin
            chk("R5 ready after reset", int'(ready[d]), 1);
            chk("R5 volumes after reset", int'(vol[d]), 0);
            chk("R5 noise after reset", int'(nctl[d]), 0);
            chk("R5 levels after reset", int'(lvl[d]), 0);
            chk("R5 tone2 after reset", int'(t2p[d]), 0);
        end
    endtask

    task automatic t_first_tick;
        int n;
        n = 0;
        while (lvl[0][0] == 1'b0 && n < LIM) begin
            @(negedge clk);
            n++;
        end
        chk("R6 first tick on edge DIV", n, 8);
    endtask

    task automatic t_pointer_reset;
        int c;
        put(0, 8'h06);
        chk("R5 default pointer 0 leaves volumes", int'(vol[0]), 0);
        put(1, 8'h06);
        chk("R5 short-zero pointer 3 hits volume 1", int'(vol[1]), 16'h0060);
        half_wave(0, 0, c);
        chk("R2 R7 period 0x060 via pointer 0", c, 96 * 8);
    endtask

    task automatic t_short_zero;
        int c;
        half_wave(1, 2, c);
        chk("R8 zero period toggles every tick", c, 1);
        put(1, 8'h85);
        put(1, 8'h00);
        half_wave(1, 0, c);
        chk("R7 R6 undivided period 5", c, 5);
        put(1, 8'hA0);
        chk("R9 undivided ready low after write", int'(ready[1]), 0);
        @(negedge clk);
        chk("R9 undivided ready low one more clock", int'(ready[1]), 0);
        @(negedge clk);
        chk("R9 undivided ready back high", int'(ready[1]), 1);
    endtask

    task automatic t_tone_periods;
        int c;
        put(0, 8'h85);
        put(0, 8'h01);
        half_wave(0, 0, c);
        chk("R1 R2 latch low then data high, period 0x015", c, 21 * 8);
        put(0, 8'hA3);
        half_wave(0, 1, c);
        chk("R4 register 2 drives channel 1", c, 3 * 8);
        put(0, 8'hC7);
        put(0, 8'h2A);
        chk("R12 R2 raw tone2 period", int'(t2p[0]), 10'h2A7);
        put(0, 8'hC0);
        put(0, 8'h00);
        chk("R12 tone2 period cleared", int'(t2p[0]), 0);
        half_wave(0, 2, c);
        chk("R8 zero period acts as 1024", c, 1024 * 8);
    endtask

    task automatic t_volume;
        put(0, 8'h9A);
        chk("R1 R12 latch volume 0", int'(vol[0][3:0]), 4'hA);
        put(0, 8'h07);
        chk("R3 data byte to volume 0", int'(vol[0][3:0]), 4'h7);
        put(0, 8'hBC);
        put(0, 8'hD5);
        put(0, 8'hF3);
        chk("R4 volume packing", int'(vol[0]), 16'h35C7);
    endtask

    task automatic t_noise;
        put(0, 8'hE5);
        chk("R11 noise latch value", int'(nctl[0]), 4'h5);
        chk("R11 strobe high", int'(nwr[0]), 1);
        @(negedge clk);
        chk("R11 strobe one clock", int'(nwr[0]), 0);
        put(0, 8'h02);
        chk("R3 data byte to noise", int'(nctl[0]), 4'h2);
        chk("R11 strobe on data byte", int'(nwr[0]), 1);
    endtask

    task automatic t_strict;
        put(2, 8'h94);
        put(2, 8'h0B);
        chk("R10 dropped volume data", int'(vol[2][3:0]), 4'h4);
        chk("R9 ready low after dropped write", int'(ready[2]), 0);
        put(2, 8'hE6);
        put(2, 8'h01);
        chk("R10 dropped noise data", int'(nctl[2]), 4'h6);
        chk("R10 no strobe on dropped data", int'(nwr[2]), 0);
        put(2, 8'hFE);
        put(2, 8'h03);
        chk("R10 dropped volume 3 data", int'(vol[2][15:12]), 4'hE);
        put(2, 8'hC1);
        put(2, 8'h3F);
        chk("R10 tone data still applied", int'(t2p[2]), 10'h3F1);
    endtask

    task automatic t_ready;
        put(0, 8'h9A);
        chk("R9 ready low after write", int'(ready[0]), 0);
        repeat (8) @(negedge clk);
        chk("R9 ready low at least DIV+1", int'(ready[0]), 0);
        repeat (8) @(negedge clk);
        chk("R9 ready high by 2*DIV", int'(ready[0]), 1);
    endtask

    initial begin
        for (int d = 0; d < 3; d++) begin
            wr_en[d]   = 1'b0;
            wr_byte[d] = 8'h00;
        end
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_tick();
        t_pointer_reset();
        t_short_zero();
        t_tone_periods();
        t_volume();
        t_noise();
        t_strict();
        t_ready();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule